// File: doc/BRIEF.md
# Slow-Write Nonvolatile Memory Model

This block is a cycle-accurate, synthesizable model of a resistive-style nonvolatile RAM. It exists so that a processor subsystem can be run against a memory whose writes are much slower than its reads. The measured write delay is set through a parameter, so the total time the processor loses can be read out directly. Reads behave like an ordinary synchronous SRAM. Writes are latched into holding registers and reach the storage array only after the programmed number of cycles. A busy flag tells the requester when the next write may be issued. Reset returns the control logic to its idle state and leaves the stored contents as they were.

The write controller is a two-state machine. `WST_IDLE` accepts a write. `WST_PROGRAM` counts down while the captured word is being programmed. There are two transitions. START goes from `WST_IDLE` to `WST_PROGRAM` when a write is accepted and `WR_LAT` is greater than 1. FINISH goes from `WST_PROGRAM` back to `WST_IDLE` on the edge where the countdown is zero, and that edge commits the word to the array. In every other case the machine stays in its current state. With `WR_LAT` equal to 1 the machine never leaves `WST_IDLE`, and an accepted write goes straight to the array on the accepting edge.

Top module: `slow_write_nvm`

## Requirements
- R1: A write accepted at clock edge E0 is committed at edge E0+WR_LAT-1, whatever `en` does after acceptance. Until that edge the location returns its previous value, and from the next read onward it returns the new word.
- R2: When `en` and `rd` are both high at an edge, `rdata` shows the word at `raddr` and `rvalid` is 1 immediately after that edge.
- R3: When `en` is high and `rd` is low at an edge, `rdata` becomes all zeros and `rvalid` becomes 0 after that edge. This is the idle output.
- R4: When `en` is low at an edge, no read and no write happen, and `rdata` and `rvalid` keep their values.
- R5: `busy` is high for exactly WR_LAT-1 cycles, starting right after the accepting edge. A write request (`en` and `wr` high) while `busy` is high is ignored, and `wr_err` is 1 for the cycle after that request.
- R6: The write address and data are captured at acceptance. Changes on `waddr` or `wdata` while the write is pending do not affect what is committed.
- R7: Reads are never stalled. A read of the pending address, including a read on the commit edge itself, returns the old stored value.
- R8: With WR_LAT = 1, a write is committed on its accepting edge, as in a plain SRAM, and `busy` and `stall_cycles` stay at 0. A read on that same edge returns the old value.
- R9: `stall_cycles` increases by one for every cycle `busy` is high, so each accepted write adds WR_LAT-1.
- R10: Reset (`rst_n` low) clears `busy`, `wr_err`, `rvalid`, `rdata` and `stall_cycles`, and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, control state only |
| en | input | 1 | Common qualifier for reads and write requests |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write request strobe |
| raddr | input | ADDR_W | Read address |
| waddr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when idle |
| rvalid | output | 1 | Read data valid, stands in for a released output |
| busy | output | 1 | A write is being programmed |
| wr_err | output | 1 | One-cycle flag for a write rejected while busy |
| stall_cycles | output | CNT_W | Running total of busy cycles |

## Verification
The assertions assume that `en`, `rd`, `wr` and both addresses are known values whenever `rst_n` is high. They also assume that `stall_cycles` never wraps inside one run, because the increment check compares against the previous value plus one. The bench changes inputs only on falling edges, holds every strobe low during reset, and writes every location before reading it, so that no read returns unwritten contents. Its runs are short enough that the 32-bit stall counter stays far from wrapping.

// File: rtl/slow_nvm_pkg.sv
package slow_nvm_pkg;
    typedef enum logic {
        WST_IDLE    = 1'b0,
        WST_PROGRAM = 1'b1
    } wst_e;
endpackage

// File: rtl/slow_nvm_wctrl.sv
module slow_nvm_wctrl
    import slow_nvm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WR_LAT = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              wr_err,
    output logic [CNT_W-1:0]  stall_cycles,
    output logic              cmt_en,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [DATA_W-1:0] cmt_data
);
    localparam int LAT_W = (WR_LAT > 2) ? $clog2(WR_LAT - 1) : 1;
    localparam logic [LAT_W-1:0] CNT_LOAD = LAT_W'((WR_LAT > 1) ? WR_LAT - 2 : 0);
    localparam bit DIRECT = (WR_LAT == 1);

    wst_e              state_q, state_d;
    logic [LAT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              err_q;
    logic [CNT_W-1:0]  stall_q;
    logic              accept;

    assign accept = en && wr && (state_q == WST_IDLE);
    assign busy   = (state_q == WST_PROGRAM);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WST_IDLE:    if (accept && !DIRECT) state_d = WST_PROGRAM;
            WST_PROGRAM: if (cnt_q == '0)       state_d = WST_IDLE;
            default:                            state_d = WST_IDLE;
        endcase
    end

    // State register and countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= CNT_LOAD;
            else if (busy && (cnt_q != '0))
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Holding registers: data path only, not reset
    always_ff @(posedge clk) begin
        if (accept) begin
            hold_addr_q <= waddr;
            hold_data_q <= wdata;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            stall_q <= '0;
        end else begin
            err_q   <= en && wr && busy;
            stall_q <= stall_q + CNT_W'(busy);
        end
    end

    assign wr_err       = err_q;
    assign stall_cycles = stall_q;

    generate
        if (DIRECT) begin : g_direct
            assign cmt_en   = accept;
            assign cmt_addr = waddr;
            assign cmt_data = wdata;

            AST_DIRECT_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                !busy); // R8
        end else begin : g_delayed
            assign cmt_en   = busy && (cnt_q == '0);
            assign cmt_addr = hold_addr_q;
            assign cmt_data = hold_data_q;

            AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                busy && $past(busy) |-> $stable(hold_addr_q) && $stable(hold_data_q)); // R6
        end
    endgenerate

    // Checker counter for the busy window length
    logic [31:0] chk_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_run_q <= '0;
        else if (busy) chk_run_q <= chk_run_q + 1;
        else           chk_run_q <= '0;
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> chk_run_q == 32'(WR_LAT - 1)); // R1
    AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        en && wr && busy |=> wr_err); // R5
    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(busy) && $past(en) && $past(wr)); // R5
    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> stall_cycles == $past(stall_cycles) + 1'b1); // R9
endmodule

// File: rtl/slow_nvm_array.sv
module slow_nvm_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              cmt_en,
    input  logic [ADDR_W-1:0] cmt_addr,
    input  logic [DATA_W-1:0] cmt_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: never reset, it models a nonvolatile array
    always_ff @(posedge clk) begin
        if (cmt_en) mem[cmt_addr] <= cmt_data;
    end

    // Read port: old value on a same-edge commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (en) begin
            if (rd) begin
                rdata  <= mem[raddr];
                rvalid <= 1'b1;
            end else begin
                rdata  <= '0;
                rvalid <= 1'b0;
            end
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        en && rd |=> rvalid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        en && !rd |=> !rvalid && rdata == '0); // R3
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata) && $stable(rvalid)); // R4
endmodule

// File: rtl/slow_write_nvm.sv
module slow_write_nvm #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WR_LAT = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              busy,
    output logic              wr_err,
    output logic [CNT_W-1:0]  stall_cycles
);
    logic              cmt_en;
    logic [ADDR_W-1:0] cmt_addr;
    logic [DATA_W-1:0] cmt_data;

    slow_nvm_wctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT), .CNT_W(CNT_W)
    ) wctrl_i (
        .clk(clk), .rst_n(rst_n), .en(en), .wr(wr),
        .waddr(waddr), .wdata(wdata),
        .busy(busy), .wr_err(wr_err), .stall_cycles(stall_cycles),
        .cmt_en(cmt_en), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
    );

    slow_nvm_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) array_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rd(rd), .raddr(raddr),
        .cmt_en(cmt_en), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .rdata(rdata), .rvalid(rvalid)
    );

    AST_WR_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> WR_LAT >= 1); // R1
endmodule

// File: tb/slow_write_nvm_tb_top.sv
`timescale 1ns/1ps
module slow_write_nvm_tb_top;
    localparam int TB_LAT = 4;

    typedef struct {
        logic [7:0] d;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Main DUT (slow writes)
    logic       en = 0, rd = 0, wr = 0;
    logic [3:0] raddr = 0, waddr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rvalid, busy, wr_err;
    logic [31:0] stall;

    // Second DUT (single-cycle writes)
    logic       b_en = 0, b_rd = 0, b_wr = 0;
    logic [3:0] b_raddr = 0, b_waddr = 0;
    logic [7:0] b_wdata = 0;
    logic [7:0] b_rdata;
    logic       b_rvalid, b_busy, b_err;
    logic [31:0] b_stall;

    slow_write_nvm #(.ADDR_W(4), .DATA_W(8), .WR_LAT(TB_LAT), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rd(rd), .wr(wr),
        .raddr(raddr), .waddr(waddr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .busy(busy), .wr_err(wr_err),
        .stall_cycles(stall)
    );

    slow_write_nvm #(.ADDR_W(4), .DATA_W(8), .WR_LAT(1), .CNT_W(32)) dut_lat1_i (
        .clk(clk), .rst_n(rst_n), .en(b_en), .rd(b_rd), .wr(b_wr),
        .raddr(b_raddr), .waddr(b_waddr), .wdata(b_wdata),
        .rdata(b_rdata), .rvalid(b_rvalid), .busy(b_busy), .wr_err(b_err),
        .stall_cycles(b_stall)
    );

    logic [7:0] tb_mem [16];
    exp_t       sb_q[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        en = 0; rd = 0; wr = 0;
    endtask

    // Driver: issue a read and queue the expected word
    task automatic rd_push(input logic [3:0] a, input string tag);
        en = 1; rd = 1; raddr = a;
        sb_q.push_back('{d: tb_mem[a], tag: tag});
    endtask

    task automatic wr_full(input logic [3:0] a, input logic [7:0] d);
        step(); en = 1; wr = 1; rd = 0; waddr = a; wdata = d;
        step(); idle();
        repeat (TB_LAT - 2) step();
        tb_mem[a] = d;
    endtask

    // Monitor: compare each completed read with the scoreboard
    always @(posedge clk) begin
        logic took;
        took = en && rd && rst_n;
        #1;
        if (took) begin
            if (sb_q.size() == 0) begin
                chk("R2 unexpected read", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, {55'd0, rvalid, rdata}, {55'd0, 1'b1, e.d});
            end
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1;
        step();
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 wr_err", wr_err, 0);
        chk("R10 rvalid", rvalid, 0);
        chk("R10 rdata", rdata, 0);
        chk("R10 stall", stall, 0);

        for (int a = 0; a < 16; a++) wr_full(4'(a), 8'(a * 29 + 7));
        step();
        chk("R9 stall after fill", stall, 16 * (TB_LAT - 1));

        // R2 back-to-back reads
        for (int a = 0; a < 16; a++) begin
            step(); rd_push(4'(a), "R2");
        end
        step(); idle();

        // R3 idle output
        step(); en = 1; rd = 0;
        step(); chk("R3 rvalid", rvalid, 0); chk("R3 rdata", rdata, 0);
        idle();

        // R4 disabled cycle
        step(); rd_push(5, "R4");
        step(); en = 0; rd = 1; wr = 1; raddr = 6; waddr = 6; wdata = 8'hEE;
        step(); chk("R4 rdata held", rdata, tb_mem[5]); chk("R4 rvalid held", rvalid, 1);
        chk("R4 no write accepted", busy, 0);
        idle();
        step(); rd_push(6, "R4");
        step(); idle();

        // Pending write: R1 R5 R6 R7
        step(); en = 1; wr = 1; waddr = 3; wdata = 8'hC3; rd_push(3, "R7");
        step(); chk("R5 busy set", busy, 1);
        wr = 1; waddr = 7; wdata = 8'h11; rd_push(3, "R7");
        step(); chk("R5 err pulse", wr_err, 1);
        wr = 0; waddr = 9; wdata = 8'hFF; rd_push(3, "R7");
        step(); chk("R5 err single", wr_err, 0); chk("R1 busy before commit", busy, 1);
        rd_push(3, "R1");
        step(); chk("R5 busy cleared", busy, 0);
        tb_mem[3] = 8'hC3; rd_push(3, "R1");
        step(); rd_push(7, "R5");
        step(); rd_push(9, "R6");
        step(); idle();
        chk("R9 stall after pending", stall, 17 * (TB_LAT - 1));

        // R10 reset keeps contents
        step(); rst_n = 0;
        step(); chk("R10 stall cleared", stall, 0); chk("R10 rvalid cleared", rvalid, 0);
        rst_n = 1;
        step(); rd_push(3, "R10");
        step(); rd_push(12, "R10");
        step(); idle();

        // R8 single-cycle write variant
        step(); b_en = 1; b_wr = 1; b_waddr = 2; b_wdata = 8'h10;
        step(); chk("R8 busy", b_busy, 0);
        b_wdata = 8'h66; b_rd = 1; b_raddr = 2;
        step(); chk("R8 same-edge read old", b_rdata, 8'h10); chk("R8 busy", b_busy, 0);
        b_wr = 0;
        step(); chk("R8 new value", b_rdata, 8'h66);
        b_en = 0; b_rd = 0;
        step(); chk("R8 stall", b_stall, 0); chk("R8 err", b_err, 0);

        repeat (2) step();
        chk("R2 scoreboard drained", sb_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule